// File: doc/BRIEF.md
# Table-Driven Count Compare Sequencer

The sequencer holds a small table of records. Each record pairs a 32-bit comparison value with a frequency setpoint in hertz. Only one record is active at a time. The block watches an external 32-bit count. When that count equals the active record's comparison value, the record's frequency is copied into an output register that a downstream pulse generator reads, and the record pointer moves to the next entry. When the last record in use matches, a done flag is raised and the pointer returns to the first record.

Software or a controller fills the table through a simple write port and sets the number of records in use. It then raises the enable input. A closing record whose comparison value and frequency are both zero brings the driven system to rest. The sequencer then waits at that record until the count is returned to zero from outside, and that match closes the pass.

Top module: `count_compare_sequencer`

## Requirements
- R1: A table write stores the comparison value unchanged. It stores the frequency unchanged when it is at most 1000 and stores 1000 when it is larger. The stored frequency appears on `freq_out` once that record matches.
- R2: Only the active record is compared. `rec_idx` shows its index and `cur_cmp` shows its comparison value. A count equal to any other record's value causes no step.
- R3: When `count_in` equals `cur_cmp` in an enabled cycle, the next clock edge loads that record's frequency into `freq_out` and moves `rec_idx` to the next index.
- R4: A count that stays equal causes exactly one step. A later record with the same comparison value matches only after the count has left that value and returned to it.
- R5: When the record at index `last` matches, `done` goes to 1 and `rec_idx` goes to 0 on the same edge. Here `last` is `tbl_len` minus 1.
- R6: `done` stays at 1 until the next match or until `en` goes low, whichever comes first. Either event clears it.
- R7: While `en` is low, `rec_idx`, `done` and `freq_out` are 0 from the following edge onward. The table contents are kept.
- R8: The count is not compared in the first clock cycle after `en` rises. A count that equals the active value in that cycle causes a step only one edge later.
- R9: `freq_out` never exceeds 1000.
- R10: A record with comparison value 0 holds the sequencer at that index for any non-zero count. Its frequency is loaded once the count returns to 0.
- R11: A `tbl_len` of 0 is treated as a table with one record, so every match of record 0 sets `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the table and all state |
| en | input | 1 | Run enable; low returns the sequencer to record 0 |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 7 | Record index to write |
| tbl_cmp | input | 32 | Comparison value to write |
| tbl_freq | input | 32 | Frequency value to write (limited to 1000) |
| tbl_len | input | 8 | Number of records in use (0 acts as 1, above 128 acts as 128) |
| count_in | input | 32 | External high-speed count |
| freq_out | output | 32 | Frequency setpoint for the pulse generator |
| rec_idx | output | 7 | Index of the active record |
| cur_cmp | output | 32 | Comparison value of the active record |
| done | output | 1 | Final record in use has matched |

## Verification
A count presented in cycle N is compared in that cycle. `freq_out`, `rec_idx` and `done` change on the next rising edge. `cur_cmp` follows `rec_idx` without delay. After `en` rises, the first cycle is skipped, so the earliest step lands on the second edge. After `en` falls, the cleared values appear after one edge. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each check sees exactly one intervening rising edge. The bench counts extra falling edges where a result is due later, such as the skipped first enabled cycle and a count held equal over several cycles.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    localparam int unsigned CNT_W    = 32;
    localparam int unsigned FREQ_W   = 32;
    localparam int unsigned FREQ_MAX = 1000;
    localparam int unsigned RECS_DEF = 128;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [FREQ_W-1:0] freq_t;

    typedef struct packed {
        cnt_t  cmp;
        freq_t freq;
    } rec_t;

    typedef enum logic {
        PH_OFF = 1'b0,
        PH_RUN = 1'b1
    } phase_t;

    function automatic freq_t limit_freq(input freq_t f);
        return (f > freq_t'(FREQ_MAX)) ? freq_t'(FREQ_MAX) : f;
    endfunction

endpackage

// File: rtl/ccs_table.sv
module ccs_table
    import ccs_pkg::*;
#(
    parameter int unsigned MAX_RECS = RECS_DEF,
    localparam int unsigned IDX_W   = $clog2(MAX_RECS),
    localparam int unsigned LEN_W   = $clog2(MAX_RECS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cnt_t             wr_cmp,
    input  freq_t            wr_freq,
    input  logic [LEN_W-1:0] len,
    input  logic [IDX_W-1:0] rd_idx,
    output rec_t             rd_rec,
    output logic [IDX_W-1:0] last_idx
);

    rec_t store [MAX_RECS];
    logic [LEN_W-1:0] len_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(MAX_RECS); i++) begin
                store[i] <= '0;
            end
        end else if (wr_en) begin
            store[wr_idx] <= '{cmp: wr_cmp, freq: limit_freq(wr_freq)};
        end
    end

    assign rd_rec = store[rd_idx];

    // Record count decode: empty acts as one, oversize saturates at the table depth.
    always_comb begin
        if (len == '0) begin
            len_m1 = '0;
        end else if (len > LEN_W'(MAX_RECS)) begin
            len_m1 = LEN_W'(MAX_RECS - 1);
        end else begin
            len_m1 = len - 1'b1;
        end
        last_idx = len_m1[IDX_W-1:0];
    end

endmodule

// File: rtl/ccs_match.sv
module ccs_match
    import ccs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  cnt_t count,
    input  cnt_t cmp_val,
    output logic hit
);

    // The value last matched is latched; a new hit needs the count to leave it first.
    logic hold_q;
    cnt_t held_q;
    logic equal;
    logic still_held;

    always_comb begin
        equal      = (count == cmp_val);
        still_held = hold_q && (count == held_q);
        hit        = active && equal && !still_held;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            hold_q <= 1'b0;
            held_q <= '0;
        end else if (hit) begin
            hold_q <= 1'b1;
            held_q <= count;
        end else if (!still_held) begin
            hold_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ccs_step.sv
module ccs_step
    import ccs_pkg::*;
#(
    parameter int unsigned MAX_RECS = RECS_DEF,
    localparam int unsigned IDX_W   = $clog2(MAX_RECS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hit,
    input  freq_t            rec_freq,
    input  logic [IDX_W-1:0] last_idx,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output freq_t            freq
);

    phase_t phase_q;
    logic   at_last;

    assign active  = en && (phase_q == PH_RUN);
    assign at_last = (idx >= last_idx);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= PH_OFF;
            idx     <= '0;
            done    <= 1'b0;
            freq    <= '0;
        end else begin
            phase_q <= PH_RUN;
            if (hit) begin
                freq <= rec_freq;
                done <= at_last;
                idx  <= at_last ? '0 : idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/count_compare_sequencer.sv
module count_compare_sequencer
    import ccs_pkg::*;
#(
    parameter int unsigned MAX_RECS = RECS_DEF,
    localparam int unsigned IDX_W   = $clog2(MAX_RECS),
    localparam int unsigned LEN_W   = $clog2(MAX_RECS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_addr,
    input  logic [31:0]      tbl_cmp,
    input  logic [31:0]      tbl_freq,
    input  logic [LEN_W-1:0] tbl_len,
    input  logic [31:0]      count_in,
    output logic [31:0]      freq_out,
    output logic [IDX_W-1:0] rec_idx,
    output logic [31:0]      cur_cmp,
    output logic             done
);

    rec_t             act_rec;
    logic [IDX_W-1:0] last_idx;
    logic             active;
    logic             hit;

    ccs_table #(.MAX_RECS(MAX_RECS)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_addr),
        .wr_cmp  (tbl_cmp),
        .wr_freq (tbl_freq),
        .len     (tbl_len),
        .rd_idx  (rec_idx),
        .rd_rec  (act_rec),
        .last_idx(last_idx)
    );

    ccs_match u_match (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .count  (count_in),
        .cmp_val(act_rec.cmp),
        .hit    (hit)
    );

    ccs_step #(.MAX_RECS(MAX_RECS)) u_step (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .hit     (hit),
        .rec_freq(act_rec.freq),
        .last_idx(last_idx),
        .active  (active),
        .idx     (rec_idx),
        .done    (done),
        .freq    (freq_out)
    );

    assign cur_cmp = act_rec.cmp;

endmodule

// File: rtl/ccs_checker.sv
module ccs_checker #(
    parameter int unsigned MAX_RECS = 128,
    localparam int unsigned IDX_W   = $clog2(MAX_RECS)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [31:0]      count_in,
    input logic [31:0]      freq_out,
    input logic [IDX_W-1:0] rec_idx,
    input logic [31:0]      cur_cmp,
    input logic             done
);

    p_off_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (rec_idx == '0 && !done && freq_out == '0));

    p_freq_cap_r9: assert property (@(posedge clk) disable iff (rst)
        freq_out <= 32'd1000);

    p_prime_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !$past(en)) |=> (rec_idx == '0 && !done && freq_out == '0));

    p_done_wraps_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (rec_idx == '0));

    p_step_order_r3: assert property (@(posedge clk) disable iff (rst)
        (rec_idx != $past(rec_idx)) |-> (rec_idx == $past(rec_idx) + 1'b1 || rec_idx == '0));

    p_no_step_on_miss_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(count_in) != $past(cur_cmp)) |-> (rec_idx == $past(rec_idx)));

    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(count_in) == $past(count_in, 2) && $past(rec_idx) != $past(rec_idx, 2))
        |-> (rec_idx == $past(rec_idx)));

endmodule

bind count_compare_sequencer ccs_checker #(.MAX_RECS(MAX_RECS)) u_ccs_checker (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .count_in(count_in),
    .freq_out(freq_out),
    .rec_idx (rec_idx),
    .cur_cmp (cur_cmp),
    .done    (done)
);

// File: tb/test_count_compare_sequencer.sv
module test_count_compare_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_addr = '0;
    logic [31:0] tbl_cmp = '0;
    logic [31:0] tbl_freq = '0;
    logic [7:0]  tbl_len = '0;
    logic [31:0] count_in = '0;
    logic [31:0] freq_out;
    logic [6:0]  rec_idx;
    logic [31:0] cur_cmp;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    count_compare_sequencer i_count_compare_sequencer (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tbl_we  (tbl_we),
        .tbl_addr(tbl_addr),
        .tbl_cmp (tbl_cmp),
        .tbl_freq(tbl_freq),
        .tbl_len (tbl_len),
        .count_in(count_in),
        .freq_out(freq_out),
        .rec_idx (rec_idx),
        .cur_cmp (cur_cmp),
        .done    (done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put_rec(input int a, input int c, input int f);
        tbl_we   = 1'b1;
        tbl_addr = 7'(a);
        tbl_cmp  = 32'(c);
        tbl_freq = 32'(f);
        tick();
        tbl_we = 1'b0;
    endtask

    task automatic go_idle();
        en = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R7 reset idx", 32'(rec_idx), 0);
        chk("R7 reset done", 32'(done), 0);
        chk("R7 reset freq", freq_out, 0);
        chk("R2 reset cmp", cur_cmp, 0);
    endtask

    task automatic t_sequence();
        put_rec(0, 40, 100);
        put_rec(1, 100, 600);
        put_rec(2, 400, 1500);
        put_rec(3, 800, 40);
        tbl_len = 8'd4;
        en = 1'b1; count_in = 0;
        tick();
        count_in = 40;
        tick();
        chk("R3 idx after first match", 32'(rec_idx), 1);
        chk("R3 freq after first match", freq_out, 100);
        chk("R2 cur_cmp follows idx", cur_cmp, 100);
        count_in = 100;
        tick();
        chk("R3 idx second", 32'(rec_idx), 2);
        chk("R3 freq second", freq_out, 600);
        count_in = 40;
        tick();
        chk("R2 other record value ignored", 32'(rec_idx), 2);
        count_in = 400;
        tick();
        chk("R1 freq limited", freq_out, 1000);
        chk("R9 freq cap", 32'(freq_out <= 1000), 1);
        chk("R2 cmp of last", cur_cmp, 800);
        count_in = 800;
        tick();
        chk("R5 done set", 32'(done), 1);
        chk("R5 idx wraps", 32'(rec_idx), 0);
        chk("R1 freq stored as written", freq_out, 40);
        count_in = 801;
        tick();
        chk("R6 done held", 32'(done), 1);
        count_in = 40;
        tick();
        chk("R6 done cleared by match", 32'(done), 0);
        chk("R6 idx after restart", 32'(rec_idx), 1);
    endtask

    task automatic t_disable();
        go_idle();
        chk("R7 idx off", 32'(rec_idx), 0);
        chk("R7 freq off", freq_out, 0);
        chk("R7 done off", 32'(done), 0);
    endtask

    task automatic t_hold();
        put_rec(0, 500, 7);
        put_rec(1, 500, 9);
        tbl_len = 8'd2;
        en = 1'b1; count_in = 0;
        tick();
        count_in = 500;
        tick();
        chk("R4 first step idx", 32'(rec_idx), 1);
        chk("R4 first step freq", freq_out, 7);
        repeat (3) tick();
        chk("R4 held count no extra step", 32'(rec_idx), 1);
        chk("R4 held count freq", freq_out, 7);
        count_in = 501;
        tick();
        count_in = 500;
        tick();
        chk("R4 rematch freq", freq_out, 9);
        chk("R5 done after second", 32'(done), 1);
        chk("R5 idx wraps two", 32'(rec_idx), 0);
    endtask

    task automatic t_prime();
        go_idle();
        en = 1'b1;
        count_in = 500;
        tick();
        chk("R8 first cycle idx", 32'(rec_idx), 0);
        chk("R8 first cycle freq", freq_out, 0);
        tick();
        chk("R8 step one edge later", 32'(rec_idx), 1);
        chk("R7 table kept", freq_out, 7);
    endtask

    task automatic t_stop();
        go_idle();
        put_rec(0, 10, 200);
        put_rec(1, 20, 300);
        put_rec(2, 0, 0);
        tbl_len = 8'd3;
        en = 1'b1; count_in = 5;
        tick();
        count_in = 10;
        tick();
        chk("R3 stop table freq", freq_out, 200);
        count_in = 20;
        tick();
        chk("R10 at stop record", 32'(rec_idx), 2);
        chk("R10 stop cmp shown", cur_cmp, 0);
        count_in = 30;
        repeat (3) tick();
        count_in = 1000;
        tick();
        chk("R10 waits idx", 32'(rec_idx), 2);
        chk("R10 waits freq", freq_out, 300);
        chk("R10 waits done", 32'(done), 0);
        count_in = 0;
        tick();
        chk("R10 zero count freq", freq_out, 0);
        chk("R10 zero count done", 32'(done), 1);
        chk("R10 zero count idx", 32'(rec_idx), 0);
    endtask

    task automatic t_len_zero();
        go_idle();
        put_rec(0, 77, 55);
        tbl_len = 8'd0;
        en = 1'b1; count_in = 0;
        tick();
        count_in = 77;
        tick();
        chk("R11 single record done", 32'(done), 1);
        chk("R11 single record idx", 32'(rec_idx), 0);
        chk("R11 single record freq", freq_out, 55);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_sequence();
        t_disable();
        t_hold();
        t_prime();
        t_stop();
        t_len_zero();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule